// File: doc/BRIEF.md
# Successive-Approximation Conversion and Read Controller

This block is the digital core of an 8-bit successive-approximation converter that sits on a microprocessor bus. One bus read does two jobs. The moment chip-select and read go low together, the block starts a conversion. While that read is active, the bus also gets the result that is held in the latch. An active-low busy pin is low while a conversion runs. A hold strobe freezes the external sample-and-hold at a fixed clock edge after the request. The block then tests one bit per clock, starting with the most significant bit. For each bit it drives a trial word to the external DAC and reads back a 1-bit comparator decision. When the last bit is decided, it stores the final code.

A host can use the block in two ways:
- **Wait-state read.** The host keeps the strobes low through the whole conversion and uses busy to stall itself. The new code appears on the bus once busy rises.
- **Two-read style.** The first read starts a conversion and returns the stale code, which the host may ignore. Each later read returns the latest code and starts the next conversion. A read that lands in the first clock after busy rises only fetches data and starts nothing.

The bus is modelled with a data word plus an output-enable pin in place of a tri-state driver. All logic runs on the rising edge of one converter clock. The chip-select and read pins are sampled on that edge. The data bus is a plain read port with no flow control: the host cannot stall it, and the data is simply present while the strobes are low.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While `rst` is high, and on the edge that ends reset: `busy_n` is 1, `hold` is 0 and `data_oe` is 0. The result latch is cleared, so the first read after reset returns 0x00.
- R2: A request edge is the first sampled clock edge at which `cs_n` and `rd_n` are both 0 after they were not both 0 on the previous edge. A request edge that arrives while the block is idle, and outside the window of R10, drives `busy_n` to 0 after that same edge (call it edge E0).
- R3: `hold` is 0 after E0 and E1. It rises after E2, which is the third edge counted from E0. It stays 1 until busy is released, and it is only ever 1 while `busy_n` is 0.
- R4: Each bit of `trial` is decided MSB first, one bit per clock from E3 to E10. A bit is kept when `cmp_in` is 1 (input at or above the trial level). With an ideal comparator the stored code equals min(255, floor(256·AIN/(2·VREF) + 0.5)).
- R5: `busy_n` stays 0 through E10. It returns to 1, and the result latch takes the new code, at edge E11. `hold` falls at that same edge.
- R6: `data_oe` is 1 exactly when `cs_n` and `rd_n` are both 0 and `rst` is 0. While `data_oe` is 1, `data_out` shows the result latch; otherwise `data_out` is 0x00.
- R7: In the two-read style, the read that starts a conversion returns the code stored before that conversion.
- R8: When `cs_n` and `rd_n` stay low through a whole conversion, `data_out` carries the new code right after E11. Releasing them afterwards starts nothing.
- R9: A request edge that arrives while `busy_n` is 0 is ignored. The running conversion still ends at E11 of its own start.
- R10: A request edge sampled at E12, the first edge after busy rises, starts no conversion but still returns the code. A request edge at any later idle edge starts one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| cmp_in | input | 1 | Comparator decision: 1 when the held input is at or above the trial level |
| busy_n | output | 1 | Active-low conversion in progress |
| hold | output | 1 | High while the sample-and-hold must keep its value |
| trial | output | 8 | Trial word for the DAC: bits kept so far plus the bit under test |
| data_out | output | 8 | Result latch while the read is enabled, zero otherwise |
| data_oe | output | 1 | Bus drive enable, stands in for tri-state |

## Verification
A sequencer that has miscounted its acquisition phase shows up within three clocks of the request as `hold` rising on the wrong edge. If the one-hot trial pointer is lost, or bits are decided in the wrong order, the error surfaces only at E11. There it appears as a code that differs from the ideal threshold code read back over the bus. A wrong release time, or a restart caused by a stray request edge, moves the rise of `busy_n` away from E11. A suppression window held for too many or too few cycles shows at E12 or E13 as `busy_n` falling when it should not, or staying high when it should fall.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_DONE = 2'd3
  } sar_state_t;
endpackage

// File: rtl/sar_req_detect.sv
// Turns the level strobes into a single start pulse: edge detect on the
// combined request, gated by idle and by a one-clock window after release.
module sar_req_detect (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic idle,
  input  logic latch,
  output logic start
);
  logic req_now;
  logic req_q;
  logic quiet_q;

  assign req_now = !cs_n && !rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      quiet_q <= 1'b0;
    end else begin
      req_q   <= req_now;
      quiet_q <= latch;   // open for exactly the edge after release
    end
  end

  assign start = req_now && !req_q && idle && !quiet_q;
endmodule

// File: rtl/sar_sequencer.sv
// Phase control: acquisition count, hold strobe, bit stepping, release.
module sar_sequencer
  import sar_ctl_pkg::*;
#(
  parameter int HOLD_EDGE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic last,
  output logic busy_n,
  output logic hold,
  output logic load,
  output logic step,
  output logic latch,
  output logic idle
);
  localparam int CW = $clog2(HOLD_EDGE + 1);
  localparam logic [CW-1:0] LOAD_AT = CW'(HOLD_EDGE - 1);

  sar_state_t    state;
  logic [CW-1:0] acq_cnt;

  assign idle  = (state == ST_IDLE);
  assign load  = (state == ST_ACQ) && (acq_cnt == LOAD_AT);
  assign step  = (state == ST_CONV);
  assign latch = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      acq_cnt <= '0;
      busy_n  <= 1'b1;
      hold    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_ACQ;
          acq_cnt <= CW'(1);
          busy_n  <= 1'b0;
        end
        ST_ACQ: if (load) begin
          state <= ST_CONV;
          hold  <= 1'b1;
        end else begin
          acq_cnt <= acq_cnt + 1'b1;
        end
        ST_CONV: if (last) state <= ST_DONE;
        ST_DONE: begin
          state  <= ST_IDLE;
          busy_n <= 1'b1;
          hold   <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_approx.sv
// Successive-approximation datapath: one-hot test pointer, kept bits, result latch.
module sar_approx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic         latch,
  input  logic         cmp_in,
  output logic [W-1:0] trial,
  output logic [W-1:0] result,
  output logic         last
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] mask;
  logic [W-1:0] kept;
  logic [W-1:0] kept_nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (load)                 kept_nxt[i] = 1'b0;
      else if (step && mask[i]) kept_nxt[i] = cmp_in;
      else                      kept_nxt[i] = kept[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      kept   <= '0;
      result <= '0;
    end else begin
      kept <= kept_nxt;
      if (load)      mask <= MSB_ONLY;
      else if (step) mask <= mask >> 1;
      if (latch)     result <= kept;
    end
  end

  assign trial = kept | mask;
  assign last  = step && mask[0];
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int W         = 8,
  parameter int HOLD_EDGE = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         cmp_in,
  output logic         busy_n,
  output logic         hold,
  output logic [W-1:0] trial,
  output logic [W-1:0] data_out,
  output logic         data_oe
);
  logic start, load, step, latch, idle, last;
  logic [W-1:0] result;

  sar_req_detect u_req (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n),
    .idle(idle), .latch(latch), .start(start)
  );

  sar_sequencer #(.HOLD_EDGE(HOLD_EDGE)) u_seq (
    .clk(clk), .rst(rst), .start(start), .last(last),
    .busy_n(busy_n), .hold(hold), .load(load), .step(step),
    .latch(latch), .idle(idle)
  );

  sar_approx #(.W(W)) u_sar (
    .clk(clk), .rst(rst), .load(load), .step(step), .latch(latch),
    .cmp_in(cmp_in), .trial(trial), .result(result), .last(last)
  );

  assign data_oe  = !cs_n && !rd_n && !rst;
  assign data_out = data_oe ? result : '0;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cs_n,
  input logic         rd_n,
  input logic         busy_n,
  input logic         hold,
  input logic [W-1:0] data_out,
  input logic         data_oe
);
  always_comb begin
    if (rst === 1'b1)
      assert_reset_quiet_R1: assert (!data_oe);
  end

  assert_start_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> $past(!cs_n && !rd_n));

  assert_hold_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
    hold |-> !busy_n);

  assert_hold_drop_release_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |-> $rose(busy_n));

  assert_bus_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |-> (!data_oe && data_out == '0));

  assert_no_instant_restart_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) |=> busy_n);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .busy_n(busy_n),
  .hold(hold), .data_out(data_out), .data_oe(data_oe)
);

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, cs_n, rd_n;
  logic       cmp_in;
  logic       busy_n, hold, data_oe;
  logic [7:0] trial, data_out;

  int ain_v;
  int held_v;
  int n_chk  = 0;
  int n_fail = 0;

  sar_adc_ctrl uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .cmp_in(cmp_in),
    .busy_n(busy_n), .hold(hold), .trial(trial), .data_out(data_out),
    .data_oe(data_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Analog model: input in 1/512 steps of 2*VREF; sample-and-hold tracks while hold is low.
  always @(ain_v or hold) if (!hold) held_v = ain_v;
  assign cmp_in = (((held_v + 1) >> 1) >= int'(trial));

  function automatic int ideal(int v);
    int c = (v + 1) >> 1;
    return (c > 255) ? 255 : c;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // One conversion. Returns at the negedge after E11.
  task automatic conv(int v, bit wait_style, bit glitch, int prev, output int code);
    ain_v = v;
    @(negedge clk); cs_n = 0; rd_n = 0; #1;
    check(data_oe == 1'b1, "R6 oe on read", int'(data_oe), 1);
    check(data_out == prev[7:0], "R7 old code on starting read", int'(data_out), prev);
    @(negedge clk);                                   // after E0
    check(busy_n == 1'b0, "R2 busy low after request", int'(busy_n), 0);
    check(hold == 1'b0, "R3 hold low after E0", int'(hold), 0);
    if (!wait_style) begin cs_n = 1; rd_n = 1; end
    @(negedge clk);                                   // after E1
    check(hold == 1'b0, "R3 hold low after E1", int'(hold), 0);
    @(negedge clk);                                   // after E2
    check(hold == 1'b1, "R3 hold high after E2", int'(hold), 1);
    ain_v = (v + 137) % 512;                          // must not affect the held value
    if (!wait_style) begin
      #1;
      check(data_out == 8'h00 && !data_oe, "R6 bus quiet when not reading", int'(data_out), 0);
    end
    for (int k = 3; k <= 10; k++) begin
      @(negedge clk);
      if (glitch && k == 5) begin cs_n = 0; rd_n = 0; end
      if (glitch && k == 6) begin cs_n = 1; rd_n = 1; end
    end
    check(busy_n == 1'b0, "R5 busy still low after E10", int'(busy_n), 0);
    @(negedge clk);                                   // after E11
    code = ideal(v);
    check(busy_n == 1'b1, glitch ? "R9 release at E11 despite late request" : "R5 release at E11",
          int'(busy_n), 1);
    check(hold == 1'b0, "R3 hold low at release", int'(hold), 0);
    if (wait_style) begin
      check(data_out == code[7:0], "R8 R4 new code in wait-state read", int'(data_out), code);
      cs_n = 1; rd_n = 1;
      @(negedge clk);
      check(busy_n == 1'b1, "R8 no second conversion", int'(busy_n), 1);
    end
  endtask

  task automatic suppressed_read(int code);
    cs_n = 0; rd_n = 0; #1;
    check(data_out == code[7:0], "R10 R4 code on read in window", int'(data_out), code);
    @(negedge clk);
    check(busy_n == 1'b1, "R10 no start at E12", int'(busy_n), 1);
    @(negedge clk);
    check(busy_n == 1'b1, "R10 still idle", int'(busy_n), 1);
    cs_n = 1; rd_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    int prev, code;
    int vals[6] = '{0, 511, 1, 2, 254, 255};
    void'($urandom(32'd20240611));
    rst = 1; cs_n = 0; rd_n = 0; ain_v = 0;
    repeat (3) @(negedge clk);
    check(busy_n == 1'b1, "R1 busy high in reset", int'(busy_n), 1);
    check(hold == 1'b0, "R1 hold low in reset", int'(hold), 0);
    check(data_oe == 1'b0, "R1 oe low in reset", int'(data_oe), 0);
    cs_n = 1; rd_n = 1;
    @(negedge clk); rst = 0;
    prev = 0;  // R1: cleared latch is checked by the first read's old-code check
    foreach (vals[i]) begin
      conv(vals[i], 1'b0, 1'b0, prev, code);
      prev = code;
    end
    conv(300, 1'b0, 1'b1, prev, code);   // R9 directed
    prev = code;
    suppressed_read(prev);               // R10 directed
    conv(77, 1'b1, 1'b0, prev, code);    // R8 directed
    prev = code;
    conv(400, 1'b0, 1'b0, prev, code);
    prev = code;
    suppressed_read(prev);
    for (int n = 0; n < 40; n++) begin
      int v = int'($urandom % 512);
      bit ws = 1'($urandom % 2);
      bit gl = !ws && (($urandom % 3) == 0);
      conv(v, ws, gl, prev, code);
      prev = code;
      if (!ws && ($urandom % 4) == 0) suppressed_read(prev);
      repeat (int'($urandom % 3)) @(negedge clk);
    end
    summary();
    $finish;
  end
endmodule